// File: doc/BRIEF.md
# Cascadable Decade Counter with Seven-Segment Drive

This block counts clock edges modulo ten and turns the current digit straight into seven active-high segment lines, so one instance drives one display digit without a separate decoder. Counting halts while an inhibit input is high, and a reset input returns the digit to zero. A carry output stays high for the lower half of the count and low for the upper half. It is therefore a square wave at one tenth of the clock rate with equal high and low times, and its rising edge marks the wrap from nine to zero. A downstream stage can count on that edge.

A build-time parameter selects one of two pin personalities. The default build has a display-enable input that blanks the digit and a one-cycle registered copy of that enable for the next digit. It also has a flag that is low only while the digit reads two. The ripple build drops those functions. In their place it gives an active-high lamp test and an active-low ripple-blank input and output. Chained from the most significant digit, the ripple pins suppress leading zeros. Chained the other way, they suppress trailing zeros. Both builds have the same port list. Pins that the chosen build does not use are ignored, and the outputs it does not use are held at fixed levels.

Top module: `decade_seg_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, the digit becomes 0 and `disp_en_out` becomes 0. Reset wins over `inhibit`.
- R2: With `rst` low and `inhibit` low, each rising edge advances the digit by one, and the edge after 9 returns it to 0.
- R3: With `rst` low and `inhibit` high, a rising edge leaves the digit unchanged.
- R4: `seg[0]` is segment a through `seg[6]` segment g, active high. The digits 0 to 9 show as hex 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R5: In the default build (`RIPPLE_MODE`=0), `seg` is 00 while `disp_en_in` is low, without waiting for a clock edge.
- R6: In the default build, `disp_en_out` equals the value `disp_en_in` had at the previous rising edge. In the ripple build it is held at 1.
- R7: `carry` is 1 while the digit is 0 to 4 and 0 while it is 5 to 9.
- R8: In the default build, `count2_n` is 0 exactly while the digit is 2. In the ripple build it is held at 1.
- R9: In the ripple build, a high `lamp_test` drives `seg` to 7F. This wins over ripple blanking.
- R10: In the ripple build, `rb_out_n` is 0 exactly when `rb_in_n` is 0 and the digit is 0. Under the same condition `seg` is 00 unless lamp test is on. In the default build `rb_out_n` is held at 1, and `lamp_test` and `rb_in_n` have no effect on `seg`.
- R11: In the ripple build, `disp_en_in` has no effect on `seg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inhibit | input | 1 | High stops counting |
| disp_en_in | input | 1 | Display enable, low blanks (default build) |
| lamp_test | input | 1 | High lights all segments (ripple build) |
| rb_in_n | input | 1 | Ripple-blank input, active low (ripple build) |
| seg | output | 7 | Segments a..g in bits 0..6, active high |
| disp_en_out | output | 1 | Registered copy of display enable |
| carry | output | 1 | Divide-by-ten square wave |
| count2_n | output | 1 | Low while the digit is 2 |
| rb_out_n | output | 1 | Ripple-blank output, active low |

## Verification
Two instances, one of each build, share the clock, reset and inhibit. This lets the bench compare each build against what the other build holds fixed. A long uninterrupted count checks every segment code, the carry duty and the single low slot of the count-2 flag. It also separates a correct wrap at nine from an off-by-one modulus. Held inhibit and reset asserted together with inhibit expose wrong priority ordering. Random mixes of display enable, lamp test and ripple-blank input at all digits separate zero-only ripple blanking from blanking of every digit. The same mixes show whether lamp test wins over blanking and whether each build ignores the pins of the other.

// File: rtl/decseg_pkg.sv
package decseg_pkg;

    localparam int MODULUS = 10;
    localparam int CNT_W   = $clog2(MODULUS);
    localparam int HALF    = MODULUS / 2;
    localparam int SEG_W   = 7;

    typedef logic [CNT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0] seg_t;

    // bit 0 = segment a ... bit 6 = segment g, active high
    function automatic seg_t digit_to_seg(input digit_t d);
        seg_t s;
        case (d)
            digit_t'(0): s = 7'h3F;
            digit_t'(1): s = 7'h06;
            digit_t'(2): s = 7'h5B;
            digit_t'(3): s = 7'h4F;
            digit_t'(4): s = 7'h66;
            digit_t'(5): s = 7'h6D;
            digit_t'(6): s = 7'h7D;
            digit_t'(7): s = 7'h07;
            digit_t'(8): s = 7'h7F;
            digit_t'(9): s = 7'h6F;
            default:     s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/decade_core.sv
module decade_core #(
    parameter int MODULUS = 10,
    localparam int CW     = $clog2(MODULUS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inhibit,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else if (!inhibit) begin
            if (st_q.cnt == LAST) st_d.cnt = '0;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> cnt_o == '0);

    a_r3_inhibit_holds: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> $stable(cnt_o));

    a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && cnt_o != LAST) |=> cnt_o == $past(cnt_o) + 1'b1);

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && cnt_o == LAST) |=> cnt_o == '0);

    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= LAST);

endmodule

// File: rtl/seg_stage.sv
module seg_stage
    import decseg_pkg::*;
(
    input  digit_t digit,
    input  logic   blank,
    input  logic   lamp,
    output seg_t   seg
);

    always_comb begin
        if (lamp)       seg = '1;
        else if (blank) seg = '0;
        else            seg = digit_to_seg(digit);
    end

endmodule

// File: rtl/en_delay.sv
module en_delay #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic en_in,
    output logic en_out
);

    typedef struct packed {
        logic en;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) st_d.en = RESET_VAL;
        else     st_d.en = en_in;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en_out = st_q.en;

    a_r6_one_cycle_copy: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> en_out == $past(en_in));

    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> en_out == RESET_VAL);

endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
    import decseg_pkg::*;
#(
    parameter bit RIPPLE_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inhibit,
    input  logic             disp_en_in,
    input  logic             lamp_test,
    input  logic             rb_in_n,
    output logic [SEG_W-1:0] seg,
    output logic             disp_en_out,
    output logic             carry,
    output logic             count2_n,
    output logic             rb_out_n
);

    digit_t cnt_w;
    logic   blank_w;
    logic   lamp_w;

    decade_core #(.MODULUS(MODULUS)) u_core (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .cnt_o   (cnt_w)
    );

    seg_stage u_seg (
        .digit (cnt_w),
        .blank (blank_w),
        .lamp  (lamp_w),
        .seg   (seg)
    );

    assign carry = (cnt_w < CNT_W'(HALF));

    generate
        if (RIPPLE_MODE) begin : g_ripple
            logic zero_hit;
            logic unused_pins;

            assign zero_hit    = !rb_in_n && (cnt_w == '0);
            assign blank_w     = zero_hit;
            assign lamp_w      = lamp_test;
            assign rb_out_n    = !zero_hit;
            assign disp_en_out = 1'b1;
            assign count2_n    = 1'b1;
            assign unused_pins = disp_en_in;

            a_r9_lamp_lights_all: assert property (@(posedge clk) disable iff (rst)
                lamp_test |-> seg == '1);

            a_r10_ripple_blanks: assert property (@(posedge clk) disable iff (rst)
                (!rb_out_n && !lamp_test) |-> seg == '0);

            a_r10_ripple_zero_only: assert property (@(posedge clk) disable iff (rst)
                !rb_out_n |-> cnt_w == '0);
        end else begin : g_enable
            logic unused_pins;

            en_delay #(.RESET_VAL(1'b0)) u_dly (
                .clk    (clk),
                .rst    (rst),
                .en_in  (disp_en_in),
                .en_out (disp_en_out)
            );

            assign blank_w     = !disp_en_in;
            assign lamp_w      = 1'b0;
            assign rb_out_n    = 1'b1;
            assign count2_n    = !(cnt_w == digit_t'(2));
            assign unused_pins = lamp_test ^ rb_in_n;

            a_r5_disabled_dark: assert property (@(posedge clk) disable iff (rst)
                !disp_en_in |-> seg == '0);
        end
    endgenerate

    a_r7_carry_rise_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(carry)) |-> ($past(cnt_w) == digit_t'(MODULUS - 1) && cnt_w == '0));

endmodule

// File: tb/decade_seg_counter_bench.sv
`timescale 1ns/1ps
module decade_seg_counter_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inhibit = 1'b0;
    logic de_a = 1'b1;
    logic lt_a = 1'b0;
    logic rb_a = 1'b1;
    logic de_b = 1'b1;
    logic lt_b = 1'b0;
    logic rb_b = 1'b1;

    logic [6:0] seg_a, seg_b;
    logic deo_a, deo_b, cy_a, cy_b, c2_a, c2_b, rbo_a, rbo_b;

    int checks = 0;
    int errors = 0;
    int m_cnt = 0;
    logic m_en = 1'b0;

    always #2 clk = ~clk;

    decade_seg_counter #(.RIPPLE_MODE(1'b0)) u_decade_seg_counter (
        .clk(clk), .rst(rst), .inhibit(inhibit),
        .disp_en_in(de_a), .lamp_test(lt_a), .rb_in_n(rb_a),
        .seg(seg_a), .disp_en_out(deo_a), .carry(cy_a),
        .count2_n(c2_a), .rb_out_n(rbo_a)
    );

    decade_seg_counter #(.RIPPLE_MODE(1'b1)) u_decade_seg_counter_rb (
        .clk(clk), .rst(rst), .inhibit(inhibit),
        .disp_en_in(de_b), .lamp_test(lt_b), .rb_in_n(rb_b),
        .seg(seg_b), .disp_en_out(deo_b), .carry(cy_b),
        .count2_n(c2_b), .rb_out_n(rbo_b)
    );

    function automatic logic [6:0] ref_seg(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B;
            3: return 7'h4F; 4: return 7'h66; 5: return 7'h6D;
            6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F;
            9: return 7'h6F; default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h (model digit %0d)", req, got, exp, m_cnt);
        end
    endtask

    // drive one cycle of inputs at the falling edge, check, then advance the model
    task automatic step(input logic r, input logic ih, input logic da, input logic ltb,
                        input logic rbb, input logic dab, input logic lta, input logic rba);
        logic zb;
        @(negedge clk);
        rst = r; inhibit = ih;
        de_a = da; lt_a = lta; rb_a = rba;
        de_b = dab; lt_b = ltb; rb_b = rbb;
        #1;
        // default build
        chk(da ? "R4 digit code" : "R5 display blank", {1'b0, seg_a},
            {1'b0, da ? ref_seg(m_cnt) : 7'h00});
        chk("R6 enable copy", {7'b0, deo_a}, {7'b0, m_en});
        chk("R7 carry", {7'b0, cy_a}, {7'b0, m_cnt < 5});
        chk("R8 count2 flag", {7'b0, c2_a}, {7'b0, m_cnt != 2});
        chk("R10 default rb_out", {7'b0, rbo_a}, 8'h01);
        // ripple build
        zb = !rbb && (m_cnt == 0);
        chk(ltb ? "R9 lamp test" : (zb ? "R10 ripple blank" : "R11 digit ignores enable"),
            {1'b0, seg_b}, {1'b0, ltb ? 7'h7F : (zb ? 7'h00 : ref_seg(m_cnt))});
        chk("R10 ripple out", {7'b0, rbo_b}, {7'b0, !zb});
        chk("R6 ripple enable fixed", {7'b0, deo_b}, 8'h01);
        chk("R8 ripple count2 fixed", {7'b0, c2_b}, 8'h01);
        chk("R7 carry ripple build", {7'b0, cy_b}, {7'b0, m_cnt < 5});
        // model of the coming rising edge
        if (r) begin
            m_cnt = 0; m_en = 1'b0;
        end else begin
            if (!ih) m_cnt = (m_cnt + 1) % 10;
            m_en = da;
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        m_cnt = 0; m_en = 1'b0;
        // R1: reset state, reset held together with inhibit
        step(1, 1, 1, 0, 1, 1, 0, 1);
        step(1, 0, 1, 0, 1, 1, 0, 1);
        // R10: ripple blank at digit 0, R9 lamp overriding it
        step(0, 1, 1, 0, 0, 1, 0, 1);
        step(0, 1, 1, 1, 0, 1, 1, 0);
        // R2/R4/R7/R8: long uninterrupted count through two wraps
        for (int i = 0; i < 25; i++) step(0, 0, 1, 0, 1, 0, 0, 1);
        // R3: inhibit holds
        for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 1, 1, 1, 0);
        // R5/R6: enable toggling
        for (int i = 0; i < 8; i++) step(0, 0, i[0], 0, 1, 1, 0, 1);
        // R1: reset mid count wins over inhibit
        step(1, 1, 1, 0, 1, 1, 0, 1);
        step(0, 0, 1, 0, 0, 1, 0, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 16) == 0, ($urandom % 4) == 0, ($urandom % 8) != 0,
                 ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                 $urandom % 2, $urandom % 2);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule